// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave side of a mode-0 SPI link in front of a 16K x 8 nonvolatile memory. The serial inputs (`sck`, `cs_n`, `si`, `hold_n`) are taken as already synchronous to the fabric clock `clk`, and the block finds the serial clock edges by comparing each sample with the one before it. Bits arrive most significant first. The first byte of a frame is an opcode. An array read is followed by a two-byte address, after which data bytes stream out of `so` for as long as the master keeps clocking. The address steps through the array and wraps at the top. A status read streams the status byte supplied by a neighbouring block.

The two program opcodes and the two opcodes that set or clear the program enable each raise a one-cycle strobe toward the blocks that own programming and protection. A pause input freezes the serial sequence in the middle of a frame and releases it later without losing its place. `so_oe` is high only while read data is being shifted out.

Top module: `spi_mem_cmd_if`

## Requirements
- R1: `si` is captured on the rising `sck` edge and `so` changes only after a falling `sck` edge. Opcode, address and data all travel most significant bit first.
- R2: Opcode 0x03 followed by a 16-bit address puts that address on `rd_addr`. The byte at that address is driven on `so` starting at the falling edge that follows the last address bit.
- R3: During an array read, `rd_addr` advances by one after every 8 data bits. It wraps from 0x3FFF to 0x0000, and the read continues until `cs_n` rises.
- R4: Only the low 14 bits of the received address select a byte. The top two address bits have no effect on the data returned.
- R5: Opcode 0x05 shifts `status_in` out on `so`. The status is sampled again at the start of each output byte, so repeated bytes follow its current value.
- R6: Each of 0x06 (`arm_stb`), 0x04 (`disarm_stb`), 0x01 (`stat_wr_stb`) and 0x02 (`arr_wr_stb`) gives exactly one single-cycle pulse on its own output after the 8th opcode bit. No other strobe pulses.
- R7: Any other opcode produces no strobe. It keeps `so_oe` low until `cs_n` goes high.
- R8: `hold_n` sampled low while `sck` is low pauses the frame. While paused, `sck` edges are ignored, `so` holds its value and `so_oe` is low. `hold_n` sampled high while `sck` is low resumes the frame exactly where it stopped.
- R9: After reset, no frame starts until `cs_n` goes from high to low. A `cs_n` held low through reset is not a selection.
- R10: `cs_n` high drives `so_oe` low on the next clock and aborts any partly received frame. The next frame starts again at the opcode.
- R11: `so_oe` is low during the opcode and address bytes. It rises only for the data phase of an array or status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock, synchronous sample |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| rd_addr | output | 14 | Array read address |
| rd_data | input | 8 | Array byte for `rd_addr`, valid within two clocks |
| status_in | input | 8 | Status byte to report |
| arm_stb | output | 1 | Pulse on opcode 0x06 |
| disarm_stb | output | 1 | Pulse on opcode 0x04 |
| stat_wr_stb | output | 1 | Pulse on opcode 0x01 |
| arr_wr_stb | output | 1 | Pulse on opcode 0x02 |

## Verification
The assertions assume that each `sck` level lasts at least three `clk` cycles, so that a new `rd_addr` has produced valid `rd_data` before the next falling edge loads it. They also assume that `hold_n` only changes while `sck` is low and never in the same cycle as an `sck` edge. The bench holds every `sck` phase for four clocks and returns `rd_data` from a registered pattern one clock after `rd_addr`. It moves `hold_n` only after `sck` has been driven low.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_ARM     = 8'h06;
  localparam logic [BYTE_W-1:0] OP_DISARM  = 8'h04;
  localparam logic [BYTE_W-1:0] OP_STAT_RD = 8'h05;
  localparam logic [BYTE_W-1:0] OP_STAT_WR = 8'h01;
  localparam logic [BYTE_W-1:0] OP_ARR_RD  = 8'h03;
  localparam logic [BYTE_W-1:0] OP_ARR_WR  = 8'h02;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR_HI,
    PH_ADDR_LO,
    PH_ARRAY,
    PH_STATUS,
    PH_SINK
  } phase_t;
endpackage

// File: rtl/spi_link_sync.sv
module spi_link_sync (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic hold_n,
  output logic sel,
  output logic paused,
  output logic rise,
  output logic fall
);
  logic sck_q;
  logic cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b0;
      sel    <= 1'b0;
      paused <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n)      sel <= 1'b0;
      else if (cs_q) sel <= 1'b1;
      if (cs_n || !sel) paused <= 1'b0;
      else if (!sck)    paused <= !hold_n;
    end
  end

  always_comb begin
    rise = sel && !cs_n && !paused && sck && !sck_q;
    fall = sel && !cs_n && !paused && !sck && sck_q;
  end
endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              rise,
  input  logic              si,
  output phase_t            phase,
  output logic [2:0]        bit_idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              arm_stb,
  output logic              disarm_stb,
  output logic              stat_wr_stb,
  output logic              arr_wr_stb
);
  localparam int HI_KEEP = ADDR_W - BYTE_W;
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [BYTE_W-2:0] sh;
  logic [HI_KEEP-1:0] addr_hi;
  logic [BYTE_W-1:0] byte_in;
  logic last;

  always_comb begin
    byte_in = {sh, si};
    last    = (bit_idx == 3'd7);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_addr <= '0;
      addr_hi <= '0;
      sh      <= '0;
    end else if (sel && rise) begin
      sh <= byte_in[BYTE_W-2:0];
      if (last && phase == PH_ADDR_HI) addr_hi <= byte_in[HI_KEEP-1:0];
      if (last && phase == PH_ADDR_LO) rd_addr <= {addr_hi, byte_in};
      if (last && phase == PH_ARRAY)   rd_addr <= rd_addr + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      phase       <= PH_OPC;
      bit_idx     <= 3'd0;
      arm_stb     <= 1'b0;
      disarm_stb  <= 1'b0;
      stat_wr_stb <= 1'b0;
      arr_wr_stb  <= 1'b0;
    end else begin
      arm_stb     <= 1'b0;
      disarm_stb  <= 1'b0;
      stat_wr_stb <= 1'b0;
      arr_wr_stb  <= 1'b0;
      if (rise) begin
        bit_idx <= bit_idx + 3'd1;
        if (last) begin
          case (phase)
            PH_OPC: begin
              case (byte_in)
                OP_ARR_RD:  phase <= PH_ADDR_HI;
                OP_STAT_RD: phase <= PH_STATUS;
                OP_ARM:     begin arm_stb     <= 1'b1; phase <= PH_SINK; end
                OP_DISARM:  begin disarm_stb  <= 1'b1; phase <= PH_SINK; end
                OP_STAT_WR: begin stat_wr_stb <= 1'b1; phase <= PH_SINK; end
                OP_ARR_WR:  begin arr_wr_stb  <= 1'b1; phase <= PH_SINK; end
                default:    phase <= PH_SINK;
              endcase
            end
            PH_ADDR_HI: phase <= PH_ADDR_LO;
            PH_ADDR_LO: phase <= PH_ARRAY;
            default:    phase <= phase;
          endcase
        end
      end
    end
  end

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ARRAY && $past(phase) == PH_ARRAY) |->
      (rd_addr == $past(rd_addr) || rd_addr == $past(rd_addr) + ONE));

  // R6
  stb_after_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (arm_stb || disarm_stb || stat_wr_stb || arr_wr_stb) |-> $past(rise));
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
  import spi_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              fall,
  input  logic              tx_phase,
  input  logic [2:0]        bit_idx,
  input  logic [BYTE_W-1:0] src,
  output logic              so,
  output logic              oe
);
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      so <= 1'b0;
      sh <= '0;
      oe <= 1'b0;
    end else if (cs_n) begin
      oe <= 1'b0;
    end else if (fall && tx_phase) begin
      oe <= 1'b1;
      if (bit_idx == 3'd0) begin
        so <= src[BYTE_W-1];
        sh <= {src[BYTE_W-2:0], 1'b0};
      end else begin
        so <= sh[BYTE_W-1];
        sh <= {sh[BYTE_W-2:0], 1'b0};
      end
    end
  end

  // R10
  cs_release_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !oe);

  // R11
  oe_phase_chk: assert property (@(posedge clk) disable iff (rst)
    oe |-> tx_phase);
endmodule

// File: rtl/spi_mem_cmd_if.sv
module spi_mem_cmd_if
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic [BYTE_W-1:0] status_in,
  output logic              arm_stb,
  output logic              disarm_stb,
  output logic              stat_wr_stb,
  output logic              arr_wr_stb
);
  logic sel, paused, rise, fall;
  phase_t phase;
  logic [2:0] bit_idx;
  logic tx_phase;
  logic oe_q;
  logic [BYTE_W-1:0] tx_src;

  spi_link_sync u_sync (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
    .sel(sel), .paused(paused), .rise(rise), .fall(fall)
  );

  spi_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst(rst), .sel(sel), .rise(rise), .si(si),
    .phase(phase), .bit_idx(bit_idx), .rd_addr(rd_addr),
    .arm_stb(arm_stb), .disarm_stb(disarm_stb),
    .stat_wr_stb(stat_wr_stb), .arr_wr_stb(arr_wr_stb)
  );

  always_comb begin
    tx_phase = (phase == PH_ARRAY) || (phase == PH_STATUS);
    tx_src   = (phase == PH_STATUS) ? status_in : rd_data;
    so_oe    = oe_q && !paused;
  end

  spi_tx_shift u_tx (
    .clk(clk), .rst(rst), .cs_n(cs_n), .fall(fall), .tx_phase(tx_phase),
    .bit_idx(bit_idx), .src(tx_src), .so(so), .oe(oe_q)
  );

  // R8
  pause_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    paused |=> $stable(so));
endmodule

// File: tb/tb_spi_mem_cmd_if.sv
module tb_spi_mem_cmd_if;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe;
  logic [13:0] rd_addr;
  logic [7:0] rd_data = 8'h00;
  logic [7:0] status_in = 8'hA5;
  logic arm_stb, disarm_stb, stat_wr_stb, arr_wr_stb;
  int checks = 0, failures = 0;
  int n_arm = 0, n_dis = 0, n_swr = 0, n_awr = 0;

  always #2 clk = ~clk;

  spi_mem_cmd_if dut (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .rd_addr(rd_addr), .rd_data(rd_data),
    .status_in(status_in), .arm_stb(arm_stb), .disarm_stb(disarm_stb),
    .stat_wr_stb(stat_wr_stb), .arr_wr_stb(arr_wr_stb)
  );

  function automatic logic [7:0] pat(input logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]} ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    rd_data <= pat(rd_addr);
    if (arm_stb) n_arm++;
    if (disarm_stb) n_dis++;
    if (stat_wr_stb) n_swr++;
    if (arr_wr_stb) n_awr++;
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
    end
  endtask

  task automatic bit_x(input logic b, output logic so_s, output logic oe_s);
    si = b;
    repeat (4) @(negedge clk);
    so_s = so;
    oe_s = so_oe;
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic byte_x(input logic [7:0] d, output logic [7:0] q,
                        output logic oe_all, output logic oe_any);
    logic s, o;
    oe_all = 1'b1;
    oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bit_x(d[i], s, o);
      q[i] = s;
      oe_all &= o;
      oe_any |= o;
    end
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_no_fall_after_reset();
    logic [7:0] q; logic a, y;
    cs_n = 1'b0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 reset so_oe", so_oe, 0);
    byte_x(8'h05, q, a, y);
    byte_x(8'h00, q, a, y);
    chk("R9 no frame without cs fall", y, 0);
    byte_x(8'h06, q, a, y);
    chk("R9 no strobe without cs fall", n_arm, 0);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_strobes();
    logic [7:0] q; logic a, y;
    int b_arm = n_arm, b_dis = n_dis, b_swr = n_swr, b_awr = n_awr;
    cs_begin(); byte_x(8'h06, q, a, y); cs_end();
    chk("R6 arm pulse", n_arm - b_arm, 1);
    cs_begin(); byte_x(8'h04, q, a, y); cs_end();
    chk("R6 disarm pulse", n_dis - b_dis, 1);
    cs_begin(); byte_x(8'h01, q, a, y); byte_x(8'h02, q, a, y); cs_end();
    chk("R6 status write pulse", n_swr - b_swr, 1);
    cs_begin(); byte_x(8'h02, q, a, y); byte_x(8'h06, q, a, y); cs_end();
    chk("R6 array write pulse", n_awr - b_awr, 1);
    chk("R6 no extra arm", n_arm - b_arm, 1);
    chk("R6 no extra disarm", n_dis - b_dis, 1);
  endtask

  task automatic t_read(input logic [15:0] addr, input int nb, input string req);
    logic [7:0] q; logic a, y, any_hdr;
    logic [13:0] exp_a = addr[13:0];
    cs_begin();
    byte_x(8'h03, q, a, y); any_hdr = y;
    byte_x(addr[15:8], q, a, y); any_hdr |= y;
    byte_x(addr[7:0], q, a, y); any_hdr |= y;
    chk({req, " R11 oe low in header"}, any_hdr, 0);
    for (int k = 0; k < nb; k++) begin
      byte_x(8'h00, q, a, y);
      chk({req, " R2/R3 data byte"}, q, pat(exp_a));
      chk({req, " R11 oe during data"}, a, 1);
      exp_a = exp_a + 14'd1;
    end
    cs_end();
    chk({req, " R10 oe low after cs"}, so_oe, 0);
  endtask

  task automatic t_status();
    logic [7:0] q; logic a, y;
    status_in = 8'hA5;
    cs_begin();
    byte_x(8'h05, q, a, y);
    byte_x(8'h00, q, a, y);
    chk("R5 status first byte", q, 8'hA5);
    status_in = 8'h3C;
    byte_x(8'h00, q, a, y);
    chk("R5 status resampled", q, 8'h3C);
    chk("R5 oe during status", a, 1);
    cs_end();
  endtask

  task automatic t_unknown();
    logic [7:0] q; logic a, y, any_o;
    int b = n_arm + n_dis + n_swr + n_awr;
    cs_begin();
    byte_x(8'hFF, q, a, y); any_o = y;
    for (int k = 0; k < 3; k++) begin byte_x(8'h03, q, a, y); any_o |= y; end
    cs_end();
    chk("R7 unknown opcode oe", any_o, 0);
    chk("R7 unknown opcode strobes", n_arm + n_dis + n_swr + n_awr - b, 0);
  endtask

  task automatic t_abort();
    logic [7:0] q; logic a, y, s, o;
    status_in = 8'h96;
    cs_begin();
    for (int i = 0; i < 4; i++) bit_x(1'b1, s, o);
    cs_end();
    cs_begin();
    byte_x(8'h05, q, a, y);
    byte_x(8'h00, q, a, y);
    cs_end();
    chk("R10 frame restarts at opcode", q, 8'h96);
  endtask

  task automatic hold_window(input string req);
    logic s0;
    hold_n = 1'b0;
    repeat (4) @(negedge clk);
    s0 = so;
    chk({req, " R8 oe low while paused"}, so_oe, 0);
    for (int k = 0; k < 3; k++) begin
      si = ~si;
      sck = 1'b1; repeat (4) @(negedge clk);
      sck = 1'b0; repeat (4) @(negedge clk);
    end
    chk({req, " R8 so frozen"}, so, s0);
    chk({req, " R8 oe still low"}, so_oe, 0);
    hold_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_hold();
    logic [7:0] q; logic a, y, s, o;
    logic [15:0] ad = 16'h2A51;
    cs_begin();
    byte_x(8'h03, q, a, y);
    for (int i = 15; i >= 10; i--) bit_x(ad[i], s, o);
    hold_window("addr");
    for (int i = 9; i >= 0; i--) bit_x(ad[i], s, o);
    for (int i = 7; i >= 5; i--) begin bit_x(1'b0, s, o); q[i] = s; end
    hold_window("data");
    for (int i = 4; i >= 0; i--) begin bit_x(1'b0, s, o); q[i] = s; end
    chk("R8 byte intact across pause", q, pat(ad[13:0]));
    byte_x(8'h00, q, a, y);
    chk("R8 next byte after pause", q, pat(ad[13:0] + 14'd1));
    cs_end();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_no_fall_after_reset();
    t_strobes();
    t_read(16'h0123, 3, "R1 plain");
    t_read(16'hC123, 2, "R4 upper bits");
    t_read(16'h3FFF, 3, "R3 wrap");
    t_status();
    t_unknown();
    t_abort();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule